// File: doc/BRIEF.md
# AES Core Register Front End

This block sits between a 32-bit word-addressed register bus and an iterative AES cipher core. Software loads a key of up to 256 bits, picks the key length, fills a 128-bit input block and then issues commands through a control register. An init command asks the core to expand the key. A next command asks the core to process the input block. The block turns each command into a one-cycle strobe towards the core and watches the core's ready line. It publishes a status ready bit that drops as soon as a command is accepted and rises again once the core has finished.

The key, key length and block seen by the core are snapshots. They are taken at the moment the command that uses them is accepted. This lets software stage the next key or block while an operation runs, without disturbing that operation. The output block is captured into result registers when a next command completes. It is held there until the following next command completes.

Top module: `aes_regif`

## Requirements
- R1: After reset, status reads 1, config reads 0, every result word reads 0 and both core strobes are low.
- R2: Key words live at word addresses 0x10 to 0x17 and block words at 0x20 to 0x23. The lowest address of each group is the most significant word (key bits 255:224, block bits 127:96). Every word reads back the value last written to it.
- R3: Config bit 0 selects the key length (0 = 128-bit, 1 = 256-bit). It reads back as written, and its value at init acceptance drives core_keylen. A 128-bit key is taken from key words 0x10 to 0x13.
- R4: While idle, writing the control register (0x00) with bit 0 set raises core_init for exactly the one cycle after the write. Writing bit 1 set, with bit 0 clear, does the same on core_next. If both bits are set, only init is issued. The control register always reads 0.
- R5: Status bit 0 (address 0x01) reads 0 from the cycle after an accepted command. It reads 1 again in the cycle after the block has seen core_ready go low and then high again.
- R6: Result words at 0x30 to 0x33 (0x30 = bits 127:96) take core_result only when a next command completes. Completion of an init command leaves them unchanged.
- R7: core_key and core_keylen change only as an init command is accepted, and core_block changes only as a next command is accepted. Writes to key, config or block registers while busy are stored but leave these outputs unchanged.
- R8: A control write while status is 0 is ignored: no strobe is issued and the running operation continues.
- R9: Reads of unmapped addresses return 0. Writes to status, result or unmapped addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cs | input | 1 | Bus access select |
| bus_we | input | 1 | Write enable (1 = write) |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| core_init | output | 1 | One-cycle key expansion strobe |
| core_next | output | 1 | One-cycle block processing strobe |
| core_keylen | output | 1 | Key length snapshot (1 = 256-bit) |
| core_key | output | 256 | Key snapshot taken at init |
| core_block | output | 128 | Block snapshot taken at next |
| core_ready | input | 1 | Core idle indication |
| core_result | input | 128 | Core output block |

## Verification
The bench stages a new key, key length and block while a next operation is running. A design that forwards live registers instead of snapshots would produce a result from the wrong key or block. Control writes issued while busy, and a write with both command bits set, are included. A design that let them through would show an extra or second strobe, or a key expansion replaced by block processing. The bench also checks that a completed init leaves the result words alone, and that status stays low across the whole window where the stub core's ready line is low. A design that captured results on any completion, or that raised ready before the core dropped its line, would diverge from the reference model on the cycle it happened.

// File: rtl/aes_regif.sv
module aes_regif #(
  parameter int AW = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_cs,
  input  logic         bus_we,
  input  logic [7:0]   bus_addr,
  input  logic [31:0]  bus_wdata,
  output logic [31:0]  bus_rdata,
  output logic         core_init,
  output logic         core_next,
  output logic         core_keylen,
  output logic [255:0] core_key,
  output logic [127:0] core_block,
  input  logic         core_ready,
  input  logic [127:0] core_result
);
  localparam logic [AW-1:0] A_CTRL = 'h00;
  localparam logic [AW-1:0] A_STAT = 'h01;
  localparam logic [AW-1:0] A_CFG  = 'h02;
  localparam logic [AW-1:0] A_KEY  = 'h10;
  localparam logic [AW-1:0] A_BLK  = 'h20;
  localparam logic [AW-1:0] A_RES  = 'h30;

  typedef enum logic [1:0] {S_IDLE, S_WLOW, S_WHIGH} st_t;

  st_t          st;
  logic         op_next;
  logic         cfg_q;
  logic [31:0]  key_q [8];
  logic [31:0]  blk_q [4];
  logic [127:0] res_q;

  logic [AW-1:0] a;
  assign a = bus_addr[AW-1:0];

  wire wr      = bus_cs && bus_we;
  wire key_hit = a[AW-1:3] == A_KEY[AW-1:3];
  wire blk_hit = a[AW-1:2] == A_BLK[AW-1:2];
  wire res_hit = a[AW-1:2] == A_RES[AW-1:2];
  wire idle    = st == S_IDLE;
  wire done    = st == S_WHIGH && core_ready;
  wire cmd_ok  = wr && a == A_CTRL && idle;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      op_next     <= 1'b0;
      cfg_q       <= 1'b0;
      res_q       <= '0;
      core_init   <= 1'b0;
      core_next   <= 1'b0;
      core_keylen <= 1'b0;
      core_key    <= '0;
      core_block  <= '0;
      for (int i = 0; i < 8; i++) key_q[i] <= '0;
      for (int i = 0; i < 4; i++) blk_q[i] <= '0;
    end else begin
      core_init <= 1'b0;
      core_next <= 1'b0;
      if (wr && key_hit) key_q[a[2:0]] <= bus_wdata;
      if (wr && blk_hit) blk_q[a[1:0]] <= bus_wdata;
      if (wr && a == A_CFG) cfg_q <= bus_wdata[0];
      if (cmd_ok && bus_wdata[0]) begin
        core_init   <= 1'b1;
        core_keylen <= cfg_q;
        core_key    <= {key_q[0], key_q[1], key_q[2], key_q[3],
                        key_q[4], key_q[5], key_q[6], key_q[7]};
        op_next     <= 1'b0;
        st          <= S_WLOW;
      end else if (cmd_ok && bus_wdata[1]) begin
        core_next  <= 1'b1;
        core_block <= {blk_q[0], blk_q[1], blk_q[2], blk_q[3]};
        op_next    <= 1'b1;
        st         <= S_WLOW;
      end else begin
        case (st)
          S_WLOW:  if (!core_ready) st <= S_WHIGH;
          S_WHIGH: if (core_ready) begin
            st <= S_IDLE;
            if (op_next) res_q <= core_result;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (a == A_STAT)    bus_rdata = {31'd0, idle};
    else if (a == A_CFG) bus_rdata = {31'd0, cfg_q};
    else if (key_hit)   bus_rdata = key_q[a[2:0]];
    else if (blk_hit)   bus_rdata = blk_q[a[1:0]];
    else if (res_hit)   bus_rdata = res_q[{~a[1:0], 5'd0} +: 32];
  end
endmodule

// File: rtl/aes_regif_chk.sv
module aes_regif_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         core_init,
  input logic         core_next,
  input logic         core_keylen,
  input logic [255:0] core_key,
  input logic [127:0] core_block,
  input logic         idle,
  input logic         done,
  input logic         op_next,
  input logic [127:0] res_q
);
  a_r4_init_single: assert property (@(posedge clk) disable iff (!rst_n)
    core_init |=> !core_init);
  a_r4_next_single: assert property (@(posedge clk) disable iff (!rst_n)
    core_next |=> !core_next);
  a_r4_one_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    !(core_init && core_next));
  a_r5_busy_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (core_init || core_next) |-> !idle);
  a_r6_res_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && op_next) |=> $stable(res_q));
  a_r7_key_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !core_init |-> (core_key == $past(core_key) && core_keylen == $past(core_keylen)));
  a_r7_blk_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !core_next |-> core_block == $past(core_block));
  a_r8_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
    (core_init || core_next) |-> $past(idle));
endmodule

bind aes_regif aes_regif_chk u_chk (
  .clk(clk), .rst_n(rst_n), .core_init(core_init), .core_next(core_next),
  .core_keylen(core_keylen), .core_key(core_key), .core_block(core_block),
  .idle(idle), .done(done), .op_next(op_next), .res_q(res_q)
);

// File: tb/test_aes_regif.sv
`timescale 1ns/1ps
module test_aes_regif;
  localparam int LAT = 5;
  logic clk = 0, rst_n = 0;
  logic bus_cs = 0, bus_we = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic core_init, core_next, core_keylen;
  logic [255:0] core_key;
  logic [127:0] core_block;
  logic core_ready;
  logic [127:0] core_result;

  always #4 clk = ~clk;

  aes_regif i_aes_regif (.*);

  function automatic logic [127:0] resf(logic [255:0] k, logic l, logic [127:0] b);
    return b ^ k[255:128] ^ (l ? k[127:0] : {4{32'hA5C3_0F1E}});
  endfunction

  // stub core
  int st_cnt;
  always @(posedge clk) begin
    if (!rst_n) begin
      core_ready <= 1'b1; st_cnt <= 0; core_result <= '0;
    end else if (core_init || core_next) begin
      core_ready <= 1'b0; st_cnt <= LAT;
    end else if (!core_ready) begin
      if (st_cnt == 0) begin
        core_ready <= 1'b1;
        core_result <= resf(core_key, core_keylen, core_block);
      end else st_cnt <= st_cnt - 1;
    end
  end

  // reference model
  logic [31:0] m_key [8];
  logic [31:0] m_blk [4];
  logic m_cfg, m_len, m_busy, m_isnext, e_init, e_next;
  logic [255:0] m_akey;
  logic [127:0] m_ablk, m_res;
  int m_cnt;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) m_key[i] = 0;
      for (int i = 0; i < 4; i++) m_blk[i] = 0;
      m_cfg = 0; m_len = 0; m_busy = 0; m_isnext = 0; e_init = 0; e_next = 0;
      m_akey = 0; m_ablk = 0; m_res = 0; m_cnt = 0;
    end else begin
      e_init = 0; e_next = 0;
      if (m_busy) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_busy = 0;
          if (m_isnext) m_res = resf(m_akey, m_len, m_ablk);
        end
      end else if (bus_cs && bus_we && bus_addr == 8'h00 && bus_wdata[1:0] != 0) begin
        m_busy = 1; m_cnt = LAT + 3;
        if (bus_wdata[0]) begin
          e_init = 1; m_isnext = 0; m_len = m_cfg;
          for (int i = 0; i < 8; i++) m_akey[255 - 32*i -: 32] = m_key[i];
        end else begin
          e_next = 1; m_isnext = 1;
          for (int i = 0; i < 4; i++) m_ablk[127 - 32*i -: 32] = m_blk[i];
        end
      end
      if (bus_cs && bus_we) begin
        if (bus_addr >= 8'h10 && bus_addr <= 8'h17) m_key[bus_addr[2:0]] = bus_wdata;
        if (bus_addr >= 8'h20 && bus_addr <= 8'h23) m_blk[bus_addr[1:0]] = bus_wdata;
        if (bus_addr == 8'h02) m_cfg = bus_wdata[0];
      end
    end
  end

  function automatic logic [31:0] mread(logic [7:0] ad);
    if (ad == 8'h01) return {31'd0, !m_busy};
    if (ad == 8'h02) return {31'd0, m_cfg};
    if (ad >= 8'h10 && ad <= 8'h17) return m_key[ad[2:0]];
    if (ad >= 8'h20 && ad <= 8'h23) return m_blk[ad[1:0]];
    if (ad >= 8'h30 && ad <= 8'h33) return m_res[127 - 32*ad[1:0] -: 32];
    return 0;
  endfunction

  function automatic string rtag(logic [7:0] ad);
    if (ad == 8'h00) return "R4";
    if (ad == 8'h01) return "R5";
    if (ad == 8'h02) return "R3";
    if (ad >= 8'h10 && ad <= 8'h23) return "R2";
    if (ad >= 8'h30 && ad <= 8'h33) return "R6";
    return "R9";
  endfunction

  int n_cmp = 0, n_bad = 0;
  logic checking = 0;
  string tag_ovr = "";

  task automatic chk(logic ok, string tag, logic [255:0] act, logic [255:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (checking) begin
    chk(core_init == e_init, "R4 R8 init", 256'(core_init), 256'(e_init));
    chk(core_next == e_next, "R4 R8 next", 256'(core_next), 256'(e_next));
    chk(core_key == m_akey, "R7 key", core_key, m_akey);
    chk(core_keylen == m_len, "R3 R7 keylen", 256'(core_keylen), 256'(m_len));
    chk(core_block == m_ablk, "R7 block", 256'(core_block), 256'(m_ablk));
    if (bus_cs && !bus_we)
      chk(bus_rdata == mread(bus_addr), tag_ovr != "" ? tag_ovr : rtag(bus_addr),
          256'(bus_rdata), 256'(mread(bus_addr)));
  end

  task automatic wr(logic [7:0] ad, logic [31:0] d);
    bus_cs = 1; bus_we = 1; bus_addr = ad; bus_wdata = d;
    @(posedge clk); #1;
    bus_cs = 0; bus_we = 0;
  endtask

  task automatic rd(logic [7:0] ad);
    bus_cs = 1; bus_we = 0; bus_addr = ad;
    @(posedge clk); #1;
    bus_cs = 0;
  endtask

  task automatic poll();
    repeat (LAT + 6) rd(8'h01);
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk); wd++;
      if (wd > 100000) begin
        n_cmp++; n_bad++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    rst_n = 1; checking = 1;
    // R1
    tag_ovr = "R1";
    rd(8'h01); rd(8'h02); rd(8'h30); rd(8'h33);
    tag_ovr = "";
    // R2 key and block staging
    for (int i = 0; i < 8; i++) wr(8'h10 + 8'(i), 32'h1111_0000 * (i + 1) ^ 32'h0000_9E37);
    for (int i = 0; i < 8; i++) rd(8'h10 + 8'(i));
    wr(8'h02, 32'hFFFF_FFFF); rd(8'h02); rd(8'h00);
    // init, 256-bit
    wr(8'h00, 32'h1); rd(8'h01); poll();
    rd(8'h30);
    for (int i = 0; i < 4; i++) wr(8'h20 + 8'(i), 32'hC0DE_0000 + 32'(i * 7));
    for (int i = 0; i < 4; i++) rd(8'h20 + 8'(i));
    // next, with staging and ignored commands while busy
    wr(8'h00, 32'h2);
    wr(8'h10, 32'hDEAD_BEEF); wr(8'h21, 32'h0BAD_F00D); wr(8'h02, 32'h0);
    wr(8'h00, 32'h1); wr(8'h00, 32'h2); rd(8'h00);
    poll();
    for (int i = 0; i < 4; i++) rd(8'h30 + 8'(i));
    // init with new 128-bit key: results unchanged
    wr(8'h00, 32'h1); poll();
    for (int i = 0; i < 4; i++) rd(8'h30 + 8'(i));
    // both bits: init only
    wr(8'h00, 32'h3); poll();
    wr(8'h00, 32'h2); poll();
    for (int i = 0; i < 4; i++) rd(8'h30 + 8'(i));
    // R9
    wr(8'h01, 32'h0); wr(8'h31, 32'h1234_5678); wr(8'h7F, 32'hFFFF_FFFF);
    rd(8'h7F); rd(8'h05); rd(8'h01); rd(8'h31); rd(8'h02);
    repeat (3) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule